// File: doc/BRIEF.md
# Binary Load Stream Parser

The block takes bytes from a character source over a valid/ready handshake and reassembles a loadable memory block from them. Everything that comes before the terminator character `!` (0x21) is a free-text header and is thrown away. Inside the header, octal digits build a 16-bit parameter value, which is captured when a carriage return arrives. After the terminator the stream carries a 16-bit start address, a 16-bit word count, that many 16-bit data words and a 16-bit checksum. Each of these is sent as two bytes with the high byte first.

Each data word goes out on a memory write port, starting at the start address and moving up one address per word. While the words arrive, a running sum is kept modulo 2^16. When the checksum bytes are complete, the parser raises a single-cycle completion pulse together with a pass/fail bit. A mismatch also places `?` (0x3F) on the console output for that cycle and sets a sticky error flag. The parser then goes back to searching for a header.

Top module: `binload_parser`

## Requirements
- R1: Bytes received before the terminator 0x21 cause no memory write and no completion pulse.
- R2: In the header, bytes 0x30..0x37 shift their low three bits into a 16-bit accumulator, dropping the oldest bits. A carriage return (0x0D) copies the accumulator to `hdr_param` and clears it. A line feed (0x0A) leaves it unchanged. Any other byte clears it.
- R3: The two bytes after the terminator form the start address, and the byte received first is bits 15:8.
- R4: Data word k is formed as {first byte, second byte}. It is written to start address + k modulo 2^16. `mem_we` is high for exactly the cycle after its second byte is accepted.
- R5: With a word count of 0, the next two bytes are taken as the checksum and no memory write takes place.
- R6: When the received checksum equals the 16-bit sum of the data words with carries discarded, `done` pulses for one cycle with `pass`=1 and `con_valid` stays low.
- R7: On a mismatch, `done` pulses with `pass`=0, `con_valid` is high in that same cycle with `con_char`=0x3F, and `err` becomes 1. `err` stays 1 until the next terminator or `clr`.
- R8: `in_ready` is low only in the completion cycle. After it, a new terminator is needed before any further write.
- R9: A high `clr` at a clock edge returns the parser to header search and clears the running sum and `err`.
- R10: After reset, `in_ready`=1, `mem_we`=0, `done`=0, `err`=0 and `hdr_param`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous restart to header search |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Parser can accept a byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| done | output | 1 | One-cycle block completion pulse |
| pass | output | 1 | Checksum matched (valid with done) |
| err | output | 1 | Sticky checksum error flag |
| con_valid | output | 1 | Console character valid |
| con_char | output | 8 | Console character |
| hdr_param | output | 16 | Last octal header value latched by carriage return |

## Verification
The bench sweeps word counts from zero upward. A design that missed the zero-count shortcut would swallow the checksum bytes as data and never complete. One block starts just below 0xFFFF, so address arithmetic that did not wrap or that skipped an index would write to the wrong places. Every third block carries a corrupted checksum, which exposes a sum that kept carries, left out a word or let the checksum into the sum, and it also exposes a missing `?` or a flag that does not stay set. Header strings mix line feeds, stray letters and over-long digit runs, which catches an accumulator that keeps stale digits or treats line feeds as separators. Bytes sent straight after a completion or after `clr` show whether the parser really returns to header search.

// File: rtl/binload_pkg.sv
`timescale 1ns/1ps
package binload_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] CH_CR = 8'h0D;
  localparam logic [BYTE_W-1:0] CH_LF = 8'h0A;

  typedef enum logic [3:0] {
    ST_HDR,
    ST_ADR_H,
    ST_ADR_L,
    ST_CNT_H,
    ST_CNT_L,
    ST_DAT_H,
    ST_DAT_L,
    ST_SUM_H,
    ST_SUM_L,
    ST_DONE
  } bl_state_e;
endpackage

// File: rtl/binload_rst_sync.sv
`timescale 1ns/1ps
module binload_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/binload_octal.sv
`timescale 1ns/1ps
module binload_octal
  import binload_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic [ACC_W-1:0]  param
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] par_q, par_d;
  logic             is_digit;
  logic             upd_en;

  assign is_digit = (din[BYTE_W-1:3] == 5'b00110);
  assign upd_en   = clr | take;

  always_comb begin
    acc_d = acc_q;
    par_d = par_q;
    if (clr) begin
      acc_d = '0;
    end else if (take) begin
      if (is_digit) begin
        acc_d = {acc_q[ACC_W-4:0], din[2:0]};
      end else if (din == CH_CR) begin
        par_d = acc_q;
        acc_d = '0;
      end else if (din != CH_LF) begin
        acc_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      par_q <= '0;
    end else if (upd_en) begin
      acc_q <= acc_d;
      par_q <= par_d;
    end
  end

  assign param = par_q;
endmodule

// File: rtl/binload_csum.sv
`timescale 1ns/1ps
module binload_csum #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] word,
  output logic [W-1:0] sum
);
  logic [W-1:0] sum_q, sum_d;
  logic         upd_en;

  assign upd_en = clr | add;

  always_comb begin
    if (clr) sum_d = '0;
    else     sum_d = sum_q + word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (upd_en) sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/binload_ctl.sv
`timescale 1ns/1ps
module binload_ctl
  import binload_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TERM_CHAR = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              hdr_take,
  output logic              sum_clr,
  output logic              sum_add,
  output logic [WORD_W-1:0] sum_word,
  input  logic [WORD_W-1:0] sum_val,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic              pass,
  output logic              err
);
  bl_state_e         state_q, state_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [WORD_W-1:0] idx_q, idx_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic              we_q, we_d;
  logic [WORD_W-1:0] waddr_q, waddr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic              pass_q, pass_d;
  logic              err_q, err_d;
  logic              acc;
  logic              is_term;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] idx_inc;

  assign in_ready = (state_q != ST_DONE);
  assign acc      = in_valid & in_ready;
  assign is_term  = (in_byte == TERM_CHAR);
  assign word     = {hi_q, in_byte};
  assign idx_inc  = idx_q + 1'b1;

  assign hdr_take = acc & (state_q == ST_HDR) & ~clr;
  assign sum_clr  = clr | (hdr_take & is_term);
  assign sum_add  = acc & (state_q == ST_DAT_L) & ~clr;
  assign sum_word = word;

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    base_d  = base_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    we_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    pass_d  = pass_q;
    err_d   = err_q;
    if (clr) begin
      state_d = ST_HDR;
      err_d   = 1'b0;
    end else if (state_q == ST_DONE) begin
      state_d = ST_HDR;
    end else if (acc) begin
      unique case (state_q)
        ST_HDR: begin
          if (is_term) begin
            state_d = ST_ADR_H;
            err_d   = 1'b0;
          end
        end
        ST_ADR_H: begin
          hi_d    = in_byte;
          state_d = ST_ADR_L;
        end
        ST_ADR_L: begin
          base_d  = word;
          state_d = ST_CNT_H;
        end
        ST_CNT_H: begin
          hi_d    = in_byte;
          state_d = ST_CNT_L;
        end
        ST_CNT_L: begin
          cnt_d   = word;
          idx_d   = '0;
          state_d = (word == '0) ? ST_SUM_H : ST_DAT_H;
        end
        ST_DAT_H: begin
          hi_d    = in_byte;
          state_d = ST_DAT_L;
        end
        ST_DAT_L: begin
          we_d    = 1'b1;
          waddr_d = base_q + idx_q;
          wdata_d = word;
          idx_d   = idx_inc;
          state_d = (idx_inc == cnt_q) ? ST_SUM_H : ST_DAT_H;
        end
        ST_SUM_H: begin
          hi_d    = in_byte;
          state_d = ST_SUM_L;
        end
        ST_SUM_L: begin
          pass_d  = (word == sum_val);
          err_d   = err_q | (word != sum_val);
          state_d = ST_DONE;
        end
        default: state_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      hi_q    <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      pass_q  <= pass_d;
      err_q   <= err_d;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = waddr_q;
  assign mem_wdata = wdata_q;
  assign done      = (state_q == ST_DONE);
  assign pass      = pass_q;
  assign err       = err_q;
endmodule

// File: rtl/binload_parser.sv
`timescale 1ns/1ps
module binload_parser
  import binload_pkg::*;
#(
  parameter logic [7:0]  TERM_CHAR = 8'h21,
  parameter logic [7:0]  ERR_CHAR  = 8'h3F,
  parameter int unsigned ACC_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [15:0]      mem_wdata,
  output logic             done,
  output logic             pass,
  output logic             err,
  output logic             con_valid,
  output logic [7:0]       con_char,
  output logic [ACC_W-1:0] hdr_param
);
  logic              rst_n_s;
  logic              hdr_take;
  logic              sum_clr;
  logic              sum_add;
  logic [WORD_W-1:0] sum_word;
  logic [WORD_W-1:0] sum_val;

  binload_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  binload_ctl #(.TERM_CHAR(TERM_CHAR)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .hdr_take  (hdr_take),
    .sum_clr   (sum_clr),
    .sum_add   (sum_add),
    .sum_word  (sum_word),
    .sum_val   (sum_val),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .pass      (pass),
    .err       (err)
  );

  binload_csum #(.W(WORD_W)) u_sum (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (sum_clr),
    .add   (sum_add),
    .word  (sum_word),
    .sum   (sum_val)
  );

  binload_octal #(.ACC_W(ACC_W)) u_oct (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (clr),
    .take  (hdr_take),
    .din   (in_byte),
    .param (hdr_param)
  );

  assign con_valid = done & ~pass;
  assign con_char  = ERR_CHAR;
endmodule

// File: rtl/binload_chk.sv
`timescale 1ns/1ps
module binload_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic done,
  input logic pass,
  input logic err,
  input logic con_valid,
  input logic mem_we
);
  a_r8_ready_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_con_only_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    con_valid |-> (done && !pass));

  a_r6_pass_quiet_console: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> !con_valid);

  a_r7_err_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> err);

  a_r1_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_we);
endmodule

bind binload_parser binload_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .done      (done),
  .pass      (pass),
  .err       (err),
  .con_valid (con_valid),
  .mem_we    (mem_we)
);

// File: tb/test_binload_parser.sv
`timescale 1ns/1ps
module test_binload_parser;
  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        done;
  logic        pass;
  logic        err;
  logic        con_valid;
  logic [7:0]  con_char;
  logic [15:0] hdr_param;

  int n_chk;
  int n_fail;

  logic [15:0] log_a [0:1023];
  logic [15:0] log_d [0:1023];
  int mon_cnt;
  int done_cnt;
  int con_cnt;

  binload_parser i_binload_parser (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .pass(pass), .err(err),
    .con_valid(con_valid), .con_char(con_char), .hdr_param(hdr_param)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    mon_cnt = 0;
    done_cnt = 0;
    con_cnt = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        log_a[mon_cnt % 1024] = mem_addr;
        log_d[mon_cnt % 1024] = mem_wdata;
        mon_cnt = mon_cnt + 1;
      end
      if (done) done_cnt = done_cnt + 1;
      if (con_valid) con_cnt = con_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_byte = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    send(w[15:8]);
    send(w[7:0]);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  function automatic logic [15:0] dval(input int b, input int i);
    return 16'((b * 16'h1357) + (i * 16'h0A0B) + 16'h80C3);
  endfunction

  // Sends a whole block; checks completion at the cycle after the last byte.
  task automatic run_block(input int b, input logic [15:0] base, input int cnt, input bit bad);
    logic [15:0] sum;
    int w0;
    int d0;
    int c0;
    sum = 16'h0;
    w0 = mon_cnt;
    d0 = done_cnt;
    c0 = con_cnt;
    send_str("ld 7\r\n");
    send(8'h21);
    send_word(base);
    send_word(16'(cnt));
    for (int i = 0; i < cnt; i++) begin
      send_word(dval(b, i));
      sum = sum + dval(b, i);
    end
    send(bad ? (sum[15:8] ^ 8'h40) : sum[15:8]);
    send(sum[7:0]);
    // now in completion cycle
    check(done == 1'b1, "R6 done pulse", done, 1);
    check(in_ready == 1'b0, "R8 ready low at completion", in_ready, 0);
    check(pass == !bad, bad ? "R7 pass low on mismatch" : "R6 pass on match", pass, !bad);
    check(con_valid == bad, "R7 console strobe", con_valid, bad);
    if (bad) check(con_char == 8'h3F, "R7 console char", con_char, 8'h3F);
    check(err == bad, "R7 error flag", err, bad);
    check((mon_cnt - w0) == cnt, cnt == 0 ? "R5 no write for zero count" : "R4 write count",
          mon_cnt - w0, cnt);
    for (int i = 0; i < cnt; i++) begin
      check(log_a[(w0 + i) % 1024] == 16'(base + i), "R3 R4 write address",
            log_a[(w0 + i) % 1024], 16'(base + i));
      check(log_d[(w0 + i) % 1024] == dval(b, i), "R4 write data",
            log_d[(w0 + i) % 1024], dval(b, i));
    end
    @(negedge clk);
    check(done == 1'b0 && in_ready == 1'b1, "R8 single completion cycle", {done, in_ready}, 1);
    check(done_cnt - d0 == 1, "R8 one completion", done_cnt - d0, 1);
    check(con_cnt - c0 == (bad ? 1 : 0), "R7 console count", con_cnt - c0, bad);
    check(hdr_param == 16'o7, "R2 header param", hdr_param, 7);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w0;
    int d0;
    n_chk = 0;
    n_fail = 0;
    clr = 1'b0;
    in_valid = 1'b0;
    in_byte = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check(in_ready == 1'b1, "R10 ready", in_ready, 1);
    check(mem_we == 1'b0, "R10 no write", mem_we, 0);
    check(done == 1'b0, "R10 done low", done, 0);
    check(err == 1'b0, "R10 err low", err, 0);
    check(hdr_param == 16'h0, "R10 param zero", hdr_param, 0);

    // R1 and R2: header contents
    w0 = mon_cnt;
    d0 = done_cnt;
    send_str("q12\r");
    check(hdr_param == 16'd10, "R2 octal 12", hdr_param, 10);
    send_str("7\n5\r");
    check(hdr_param == 16'd61, "R2 line feed ignored", hdr_param, 61);
    send_str("34x6\r");
    check(hdr_param == 16'd6, "R2 other char clears", hdr_param, 6);
    send_str("177777\r");
    check(hdr_param == 16'hFFFF, "R2 full width", hdr_param, 16'hFFFF);
    send_str("1234567\r");
    check(hdr_param == 16'd14711, "R2 oldest bits dropped", hdr_param, 14711);
    send_str("\r");
    check(hdr_param == 16'd0, "R2 empty number", hdr_param, 0);
    send(8'h00); send(8'h05); send(8'hFF);
    check(mon_cnt == w0, "R1 no write in header", mon_cnt - w0, 0);
    check(done_cnt == d0, "R1 no completion in header", done_cnt - d0, 0);

    // sweep of word counts, some with bad checksums, one wrapping address
    for (int b = 0; b < 20; b++) begin
      run_block(b, (b == 5) ? 16'hFFFE : 16'((b * 16'h0100) + 3), b, (b % 3) == 2);
    end

    // R8: bytes after completion are header until the next terminator
    w0 = mon_cnt;
    d0 = done_cnt;
    send(8'h00); send(8'h10); send(8'h00); send(8'h01); send(8'h12); send(8'h34);
    check(mon_cnt == w0, "R8 no write before terminator", mon_cnt - w0, 0);
    check(done_cnt == d0, "R8 no completion before terminator", done_cnt - d0, 0);

    // R9: restart mid-block
    send(8'h21);
    send_word(16'h0040);
    send_word(16'd3);
    send_word(16'hABCD);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    w0 = mon_cnt;
    send_word(16'h1111); send_word(16'h2222); send_word(16'h3333);
    check(mon_cnt == w0, "R9 clr returns to header search", mon_cnt - w0, 0);
    run_block(40, 16'h0200, 3, 1'b0);

    // R7 sticky flag and R9 clear of the flag
    run_block(41, 16'h0300, 2, 1'b1);
    repeat (4) @(negedge clk);
    check(err == 1'b1, "R7 err stays set", err, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(err == 1'b0, "R9 clr clears err", err, 0);
    run_block(42, 16'h0400, 1, 1'b1);
    send(8'h21);
    check(err == 1'b0, "R7 terminator clears err", err, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule